// File: doc/BRIEF.md
# Security Interrupt Status Aggregator

This block gathers interrupt levels from three families of protection logic and presents them to software as status words. The families are the peripheral protection controllers, the memory protection controllers and the expansion master security controllers. A register front end that has already decoded the bus address drives the block with a write strobe, a word offset and write data. The block answers with read data for the same offset. Read data is combinational, so the front end can register it as its timing requires.

Peripheral protection controller events go into sparse status bits. Software enables them and clears them through their own registers. The block does not clear a stored bit by itself. Each controller instead gets an enable level and a clear level, and those levels decide what the controller does with its own interrupt. Memory protection status and master security status are live views of the input levels. The master security sources also form one combined interrupt, masked by an enable register. A bridge error interrupt enable register is kept for software compatibility. Its status always reads as zero.

Top module: `secirq_agg`

## Requirements
- R1: After synchronous reset, every stored status, enable and clear level is zero: `ppc_en_out`, `ppc_clr_out`, `msc_clr_out` and `msc_irq` are low, and every register reads zero.
- R2: Peripheral controllers are numbered first by internal APB index, then APB expansion, then AHB expansion. Internal APB controller k owns status bit k. APB expansion controller k owns bit 4+k. AHB expansion controller k owns bit 20+k. When a source level changes, its status bit in the word at offset 0x20 takes the new level at the next clock edge. Otherwise the bit holds. An input already high during reset is not an event.
- R3: A write to offset 0x24 zeroes the status bits it has set. Bits outside 0x00F000F3 have no effect. Each `ppc_clr_out` bit equals its controller's stored status bit. Offset 0x24 reads zero.
- R4: A write to offset 0x28 stores the written value ANDed with 0x00F000F3, and the register reads back that value. Each `ppc_en_out` bit equals its controller's bit of this register.
- R5: Offset 0x1C reads internal memory controller n at bit n and expansion memory controller n at bit 16+n. The bits follow the inputs in the same cycle. Writes to 0x1C have no effect.
- R6: Offset 0x30 reads master security source n at bit 16+n, following the input in the same cycle. Offset 0x38 stores all 32 written bits. `msc_irq` is high exactly when (status AND enable) is nonzero, and it reacts in the same cycle as an input change.
- R7: A write to offset 0x34 sets `msc_clr_out[n]` to written bit 16+n from the next edge. The outputs hold until the next write to 0x34. Offset 0x34 reads zero.
- R8: Offset 0x48 stores written bits [31:16] and reads zero in [15:0]. Offset 0x40 always reads zero. Writes to 0x44 change nothing, and 0x44 reads zero.
- R9: When a source level changes in the same cycle as a clear write naming its bit, the new level is stored.
- R10: Writes to offset 0x20 have no effect. Any offset not named above reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the current offset |
| reg_addr | input | 12 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ppc_irq_in | input | 10 | Peripheral controller interrupt levels, numbered as in R2 |
| ppc_en_out | output | 10 | Per-controller interrupt enable level |
| ppc_clr_out | output | 10 | Per-controller interrupt clear level |
| mpc_irq_in | input | 1 | Internal memory controller interrupt levels |
| mpcx_irq_in | input | 4 | Expansion memory controller interrupt levels |
| msc_irq_in | input | 4 | Expansion master security interrupt levels |
| msc_clr_out | output | 4 | Per-source master security clear level |
| msc_irq | output | 1 | Combined master security interrupt |

## Verification
The properties assume the reset pulse lasts at least one clock. The change detector has no reset value, so only after that clock does it hold a real previous input level. The stimulus therefore keeps every source low through reset. The clear-output property assumes a source level stays steady in the cycle of a clear write. The stimulus keeps it steady in that cycle everywhere except the one deliberate collision test for R9. That test is written so that the value the clear property predicts still holds. The bench changes inputs and registers only at falling clock edges. It reads registered state one edge after the change that should produce it, and it reads the combinational paths in the same half cycle.

// File: rtl/secirq_pkg.sv
package secirq_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int APBX_LSB = 4;
    localparam int AHBX_LSB = 20;
    localparam int EXP_LSB  = 16;

    localparam logic [DATA_W-1:0] BRG_KEEP = 32'hFFFF_0000;

    localparam logic [ADDR_W-1:0] OFF_MPC_STAT = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_PPC_STAT = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_PPC_CLR  = 12'h024;
    localparam logic [ADDR_W-1:0] OFF_PPC_EN   = 12'h028;
    localparam logic [ADDR_W-1:0] OFF_MSC_STAT = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_MSC_CLR  = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_MSC_EN   = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_BRG_STAT = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_BRG_CLR  = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_BRG_EN   = 12'h048;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MPC_STAT,
        SEL_PPC_STAT,
        SEL_PPC_CLR,
        SEL_PPC_EN,
        SEL_MSC_STAT,
        SEL_MSC_CLR,
        SEL_MSC_EN,
        SEL_BRG_STAT,
        SEL_BRG_CLR,
        SEL_BRG_EN
    } reg_sel_e;

    typedef struct packed {
        logic ppc_clr;
        logic ppc_en;
        logic msc_clr;
        logic msc_en;
        logic brg_en;
    } wr_hit_t;

    // Status bit owned by peripheral controller idx in the shared word.
    function automatic int ppc_bit(int idx, int n_int, int n_apbx);
        if (idx < n_int)
            return idx;
        else if (idx < n_int + n_apbx)
            return APBX_LSB + (idx - n_int);
        else
            return AHBX_LSB + (idx - n_int - n_apbx);
    endfunction

    function automatic reg_sel_e decode_sel(logic [ADDR_W-1:0] a);
        case (a)
            OFF_MPC_STAT: return SEL_MPC_STAT;
            OFF_PPC_STAT: return SEL_PPC_STAT;
            OFF_PPC_CLR:  return SEL_PPC_CLR;
            OFF_PPC_EN:   return SEL_PPC_EN;
            OFF_MSC_STAT: return SEL_MSC_STAT;
            OFF_MSC_CLR:  return SEL_MSC_CLR;
            OFF_MSC_EN:   return SEL_MSC_EN;
            OFF_BRG_STAT: return SEL_BRG_STAT;
            OFF_BRG_CLR:  return SEL_BRG_CLR;
            OFF_BRG_EN:   return SEL_BRG_EN;
            default:      return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/secirq_ppc_bank.sv
module secirq_ppc_bank
    import secirq_pkg::*;
#(
    parameter int N_INT  = 2,
    parameter int N_APBX = 4,
    parameter int N_AHBX = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_INT+N_APBX+N_AHBX-1:0] src_in,
    input  logic                      clr_wr,
    input  logic                      en_wr,
    input  logic [N_INT+N_APBX+N_AHBX-1:0] wbits,
    output logic [DATA_W-1:0]         stat_word,
    output logic [DATA_W-1:0]         en_word,
    output logic [N_INT+N_APBX+N_AHBX-1:0] en_out,
    output logic [N_INT+N_APBX+N_AHBX-1:0] clr_out
);
    localparam int NP = N_INT + N_APBX + N_AHBX;

    logic [NP-1:0] prev_q;
    logic [NP-1:0] st_q;
    logic [NP-1:0] en_q;

    // Previous level is only an edge reference; it needs no reset value.
    always_ff @(posedge clk) begin
        prev_q <= src_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            en_q <= '0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (src_in[i] != prev_q[i])
                    st_q[i] <= src_in[i];          // a fresh event beats a clear
                else if (clr_wr && wbits[i])
                    st_q[i] <= 1'b0;
            end
            if (en_wr)
                en_q <= wbits;
        end
    end

    always_comb begin
        stat_word = '0;
        en_word   = '0;
        for (int i = 0; i < NP; i++) begin
            stat_word[ppc_bit(i, N_INT, N_APBX)] = st_q[i];
            en_word[ppc_bit(i, N_INT, N_APBX)]   = en_q[i];
        end
    end

    assign en_out  = en_q;
    assign clr_out = st_q;

endmodule

// File: rtl/secirq_msc_unit.sv
module secirq_msc_unit
    import secirq_pkg::*;
#(
    parameter int N_MSC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_MSC-1:0]  src_in,
    input  logic              en_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] en_word,
    output logic [N_MSC-1:0]  clr_out,
    output logic              irq
);
    logic [DATA_W-1:0] en_q;
    logic [N_MSC-1:0]  clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            clr_q <= '0;
        end else begin
            if (en_wr)
                en_q <= wdata;
            if (clr_wr)
                clr_q <= wdata[EXP_LSB +: N_MSC];
        end
    end

    always_comb begin
        stat_word = '0;
        stat_word[EXP_LSB +: N_MSC] = src_in;
    end

    assign en_word = en_q;
    assign clr_out = clr_q;
    assign irq     = |(stat_word & en_q);

endmodule

// File: rtl/secirq_rdmux.sv
module secirq_rdmux
    import secirq_pkg::*;
(
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] mpc_stat,
    input  logic [DATA_W-1:0] ppc_stat,
    input  logic [DATA_W-1:0] ppc_en,
    input  logic [DATA_W-1:0] msc_stat,
    input  logic [DATA_W-1:0] msc_en,
    input  logic [DATA_W-1:0] brg_en,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        case (sel)
            SEL_MPC_STAT: rdata = mpc_stat;
            SEL_PPC_STAT: rdata = ppc_stat;
            SEL_PPC_EN:   rdata = ppc_en;
            SEL_MSC_STAT: rdata = msc_stat;
            SEL_MSC_EN:   rdata = msc_en;
            SEL_BRG_EN:   rdata = brg_en;
            default:      rdata = '0;   // clear words, bridge status, unmapped
        endcase
    end
endmodule

// File: rtl/secirq_agg.sv
module secirq_agg
    import secirq_pkg::*;
#(
    parameter int N_APB_INT = 2,
    parameter int N_APB_EXP = 4,
    parameter int N_AHB_EXP = 4,
    parameter int N_MPC     = 1,
    parameter int N_MPC_EXP = 4,
    parameter int N_MSC     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [N_APB_INT+N_APB_EXP+N_AHB_EXP-1:0] ppc_irq_in,
    output logic [N_APB_INT+N_APB_EXP+N_AHB_EXP-1:0] ppc_en_out,
    output logic [N_APB_INT+N_APB_EXP+N_AHB_EXP-1:0] ppc_clr_out,
    input  logic [N_MPC-1:0]     mpc_irq_in,
    input  logic [N_MPC_EXP-1:0] mpcx_irq_in,
    input  logic [N_MSC-1:0]     msc_irq_in,
    output logic [N_MSC-1:0]     msc_clr_out,
    output logic                 msc_irq
);
    localparam int NP = N_APB_INT + N_APB_EXP + N_AHB_EXP;

    reg_sel_e          sel;
    wr_hit_t           hit;
    logic [NP-1:0]     ppc_wbits;
    logic [DATA_W-1:0] mpc_word, ppc_stat_w, ppc_en_w, msc_stat_w, msc_en_w;
    logic [DATA_W-1:0] brg_en_q;

    assign sel = decode_sel(reg_addr);

    always_comb begin
        hit         = '0;
        hit.ppc_clr = reg_wr && (sel == SEL_PPC_CLR);
        hit.ppc_en  = reg_wr && (sel == SEL_PPC_EN);
        hit.msc_clr = reg_wr && (sel == SEL_MSC_CLR);
        hit.msc_en  = reg_wr && (sel == SEL_MSC_EN);
        hit.brg_en  = reg_wr && (sel == SEL_BRG_EN);
    end

    // Gather each controller's bit out of the sparse write word.
    always_comb begin
        for (int i = 0; i < NP; i++)
            ppc_wbits[i] = reg_wdata[ppc_bit(i, N_APB_INT, N_APB_EXP)];
    end

    always_comb begin
        mpc_word = '0;
        mpc_word[N_MPC-1:0]          = mpc_irq_in;
        mpc_word[EXP_LSB +: N_MPC_EXP] = mpcx_irq_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            brg_en_q <= '0;
        else if (hit.brg_en)
            brg_en_q <= reg_wdata & BRG_KEEP;
    end

    secirq_ppc_bank #(
        .N_INT  (N_APB_INT),
        .N_APBX (N_APB_EXP),
        .N_AHBX (N_AHB_EXP)
    ) u_ppc (
        .clk       (clk),
        .rst       (rst),
        .src_in    (ppc_irq_in),
        .clr_wr    (hit.ppc_clr),
        .en_wr     (hit.ppc_en),
        .wbits     (ppc_wbits),
        .stat_word (ppc_stat_w),
        .en_word   (ppc_en_w),
        .en_out    (ppc_en_out),
        .clr_out   (ppc_clr_out)
    );

    secirq_msc_unit #(
        .N_MSC (N_MSC)
    ) u_msc (
        .clk       (clk),
        .rst       (rst),
        .src_in    (msc_irq_in),
        .en_wr     (hit.msc_en),
        .clr_wr    (hit.msc_clr),
        .wdata     (reg_wdata),
        .stat_word (msc_stat_w),
        .en_word   (msc_en_w),
        .clr_out   (msc_clr_out),
        .irq       (msc_irq)
    );

    secirq_rdmux u_rd (
        .sel      (sel),
        .mpc_stat (mpc_word),
        .ppc_stat (ppc_stat_w),
        .ppc_en   (ppc_en_w),
        .msc_stat (msc_stat_w),
        .msc_en   (msc_en_w),
        .brg_en   (brg_en_q),
        .rdata    (reg_rdata)
    );

endmodule

// File: rtl/secirq_agg_chk.sv
module secirq_agg_chk
    import secirq_pkg::*;
#(
    parameter int N_APB_INT = 2,
    parameter int N_APB_EXP = 4,
    parameter int N_AHB_EXP = 4,
    parameter int N_MSC     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic [N_APB_INT+N_APB_EXP+N_AHB_EXP-1:0] ppc_irq_in,
    input logic [N_APB_INT+N_APB_EXP+N_AHB_EXP-1:0] ppc_en_out,
    input logic [N_APB_INT+N_APB_EXP+N_AHB_EXP-1:0] ppc_clr_out,
    input logic [N_MSC-1:0]     msc_irq_in,
    input logic [N_MSC-1:0]     msc_clr_out,
    input logic                 msc_irq
);
    localparam int NP = N_APB_INT + N_APB_EXP + N_AHB_EXP;

    logic [NP-1:0] wsel;
    always_comb begin
        for (int i = 0; i < NP; i++)
            wsel[i] = reg_wdata[ppc_bit(i, N_APB_INT, N_APB_EXP)];
    end

    // R2
    ppc_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (ppc_irq_in != $past(ppc_irq_in)) |=>
        (((ppc_clr_out ^ $past(ppc_irq_in)) &
          ($past(ppc_irq_in) ^ $past(ppc_irq_in, 2))) == '0));

    // R3
    ppc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_PPC_CLR && ppc_irq_in == $past(ppc_irq_in)) |=>
        ((ppc_clr_out & $past(wsel)) == '0));

    // R4
    ppc_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_PPC_EN) |=> (ppc_en_out == $past(wsel)));

    // R6
    msc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (msc_irq_in == '0) |-> !msc_irq);

    // R7
    msc_clear_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_MSC_CLR) |=>
        (msc_clr_out == $past(reg_wdata[EXP_LSB +: N_MSC])));

    // R7
    msc_clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == OFF_MSC_CLR) |=> $stable(msc_clr_out));

    // R8
    brg_status_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_BRG_STAT) |-> (reg_rdata == '0));

    // R8
    brg_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_BRG_EN) |=>
        ((reg_addr != OFF_BRG_EN) || (reg_rdata == ($past(reg_wdata) & BRG_KEEP))));

endmodule

bind secirq_agg secirq_agg_chk #(
    .N_APB_INT (N_APB_INT),
    .N_APB_EXP (N_APB_EXP),
    .N_AHB_EXP (N_AHB_EXP),
    .N_MSC     (N_MSC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ppc_irq_in  (ppc_irq_in),
    .ppc_en_out  (ppc_en_out),
    .ppc_clr_out (ppc_clr_out),
    .msc_irq_in  (msc_irq_in),
    .msc_clr_out (msc_clr_out),
    .msc_irq     (msc_irq)
);

// File: tb/secirq_agg_test.sv
module secirq_agg_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [9:0]  ppc_irq_in;
    logic [9:0]  ppc_en_out;
    logic [9:0]  ppc_clr_out;
    logic [0:0]  mpc_irq_in;
    logic [3:0]  mpcx_irq_in;
    logic [3:0]  msc_irq_in;
    logic [3:0]  msc_clr_out;
    logic        msc_irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    secirq_agg uut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ppc_irq_in  (ppc_irq_in),
        .ppc_en_out  (ppc_en_out),
        .ppc_clr_out (ppc_clr_out),
        .mpc_irq_in  (mpc_irq_in),
        .mpcx_irq_in (mpcx_irq_in),
        .msc_irq_in  (msc_irq_in),
        .msc_clr_out (msc_clr_out),
        .msc_irq     (msc_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [9:0]  ppc;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 12'h020, 32'h0,        10'h000, 32'h0000_0000, 4'd2},  // R2 quiet
        '{1'b0, 12'h020, 32'h0,        10'h001, 32'h0000_0000, 4'd2},  // R2 not yet captured
        '{1'b0, 12'h020, 32'h0,        10'h001, 32'h0000_0001, 4'd2},  // R2 bit 0
        '{1'b0, 12'h020, 32'h0,        10'h005, 32'h0000_0001, 4'd2},
        '{1'b0, 12'h020, 32'h0,        10'h005, 32'h0000_0011, 4'd2},  // R2 bit 4
        '{1'b0, 12'h020, 32'h0,        10'h045, 32'h0000_0011, 4'd2},
        '{1'b0, 12'h020, 32'h0,        10'h045, 32'h0010_0011, 4'd2},  // R2 bit 20
        '{1'b1, 12'h024, 32'h0010_0009,10'h045, 32'h0,         4'd3},  // R3 clear
        '{1'b0, 12'h020, 32'h0,        10'h045, 32'h0000_0010, 4'd3},
        '{1'b0, 12'h020, 32'h0,        10'h044, 32'h0000_0010, 4'd3},
        '{1'b0, 12'h020, 32'h0,        10'h040, 32'h0000_0010, 4'd2},
        '{1'b0, 12'h020, 32'h0,        10'h040, 32'h0000_0000, 4'd2},  // R2 fall
        '{1'b1, 12'h028, 32'hFFFF_FFFF,10'h200, 32'h0,         4'd4},
        '{1'b0, 12'h028, 32'h0,        10'h200, 32'h00F0_00F3, 4'd4},  // R4 mask
        '{1'b0, 12'h020, 32'h0,        10'h200, 32'h0080_0000, 4'd2},  // R2 bit 23
        '{1'b1, 12'h020, 32'h0,        10'h200, 32'h0,         4'd10},
        '{1'b0, 12'h020, 32'h0,        10'h200, 32'h0080_0000, 4'd10}, // R10 ro
        '{1'b0, 12'h024, 32'h0,        10'h200, 32'h0,         4'd3},
        '{1'b1, 12'h048, 32'hFFFF_FFFF,10'h200, 32'h0,         4'd8},
        '{1'b0, 12'h048, 32'h0,        10'h200, 32'hFFFF_0000, 4'd8},  // R8
        '{1'b0, 12'h040, 32'h0,        10'h200, 32'h0,         4'd8},
        '{1'b1, 12'h044, 32'hFFFF_FFFF,10'h200, 32'h0,         4'd8},
        '{1'b0, 12'h048, 32'h0,        10'h200, 32'hFFFF_0000, 4'd8},
        '{1'b0, 12'h044, 32'h0,        10'h200, 32'h0,         4'd8},
        '{1'b0, 12'h100, 32'h0,        10'h200, 32'h0,         4'd10}  // R10 unmapped
    };

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        #1;
    endtask

    task automatic idle();
        step(1'b0, 12'h000, 32'h0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        ppc_irq_in = '0; mpc_irq_in = '0; mpcx_irq_in = '0; msc_irq_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        step(1'b0, 12'h028, 32'h0);
        check(reg_rdata, 32'h0, "R1 enable word");
        check({22'h0, ppc_en_out}, 32'h0, "R1 ppc_en_out");
        check({22'h0, ppc_clr_out}, 32'h0, "R1 ppc_clr_out");
        check({27'h0, msc_irq, msc_clr_out}, 32'h0, "R1 msc outputs");

        // Vector table
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            ppc_irq_in = TBL[k].ppc;
            reg_wr     = TBL[k].wr;
            reg_addr   = TBL[k].addr;
            reg_wdata  = TBL[k].data;
            #1;
            if (!TBL[k].wr) begin
                checks++;
                if (reg_rdata !== TBL[k].exp) begin
                    fails++;
                    $display("FAIL R%0d vector %0d: got %h expected %h",
                             TBL[k].req, k, reg_rdata, TBL[k].exp);
                end
            end
        end

        // R4 enable levels follow register, R3 clear levels follow status
        idle();
        check({22'h0, ppc_en_out}, 32'h3FF, "R4 all enables");
        check({22'h0, ppc_clr_out}, 32'h200, "R3 clear level of src9");
        step(1'b1, 12'h028, 32'h0010_0012);
        idle();
        check({22'h0, ppc_en_out}, 32'h046, "R4 sparse enables");
        step(1'b0, 12'h028, 32'h0);
        check(reg_rdata, 32'h0010_0012, "R4 enable readback");

        // R3 clear with input held
        step(1'b1, 12'h024, 32'h0080_0000);
        idle();
        check({22'h0, ppc_clr_out}, 32'h000, "R3 clear held source");

        // R9 change in same cycle as clear wins
        @(negedge clk);
        ppc_irq_in = 10'h202;
        reg_wr = 1'b1; reg_addr = 12'h024; reg_wdata = 32'h0000_0002;
        idle();
        check({22'h0, ppc_clr_out}, 32'h002, "R9 event beats clear");
        step(1'b0, 12'h020, 32'h0);
        check(reg_rdata, 32'h0000_0002, "R9 status word");

        // R5 memory protection status
        @(negedge clk);
        mpc_irq_in = 1'b1; mpcx_irq_in = 4'hA;
        reg_wr = 1'b0; reg_addr = 12'h01C;
        #1;
        check(reg_rdata, 32'h000A_0001, "R5 mpc status");
        step(1'b1, 12'h01C, 32'h0);
        step(1'b0, 12'h01C, 32'h0);
        check(reg_rdata, 32'h000A_0001, "R5 write ignored");

        // R6 master security status and combined interrupt
        @(negedge clk);
        msc_irq_in = 4'b0101;
        reg_wr = 1'b0; reg_addr = 12'h030;
        #1;
        check(reg_rdata, 32'h0005_0000, "R6 msc status");
        check({31'h0, msc_irq}, 32'h0, "R6 irq masked");
        step(1'b1, 12'h038, 32'h0004_0000);
        step(1'b0, 12'h038, 32'h0);
        check({31'h0, msc_irq}, 32'h1, "R6 irq enabled");
        check(reg_rdata, 32'h0004_0000, "R6 enable readback");
        @(negedge clk);
        msc_irq_in = 4'b0001;
        #1;
        check({31'h0, msc_irq}, 32'h0, "R6 irq drops with input");
        step(1'b1, 12'h038, 32'hFFFF_FFFF);
        step(1'b0, 12'h038, 32'h0);
        check(reg_rdata, 32'hFFFF_FFFF, "R6 full enable stored");
        check({31'h0, msc_irq}, 32'h1, "R6 irq source0");

        // R7 master security clear levels
        step(1'b1, 12'h034, 32'h000A_0000);
        idle();
        check({28'h0, msc_clr_out}, 32'hA, "R7 clear load");
        step(1'b1, 12'h048, 32'h0);
        idle();
        check({28'h0, msc_clr_out}, 32'hA, "R7 clear hold");
        step(1'b0, 12'h034, 32'h0);
        check(reg_rdata, 32'h0, "R7 clear reads zero");

        summary();
    end

endmodule